// File: doc/BRIEF.md
# Set-Associative Tag Store with Per-Line Fault Masking

This block holds the tags and line states of a set-associative cache and decides which way a new line goes into. The default geometry is 16 KB of capacity, four ways and 64-byte lines, so there are 64 sets. A lookup presents a set index and a tag. One cycle later the block reports whether the tag is present and, if so, in which way. An allocation request names a set and returns the way that should receive the new line. A fill command writes a tag and a state into one way. A separate configuration command marks one line as permanently out of service.

Each line carries a two-bit state: invalid, valid, allocated (valid and pinned for early boot use) or disabled. A disabled line never matches a lookup and is never offered as a victim. A faulty line therefore costs exactly one line of capacity, and its set keeps working with one way fewer. A build parameter can start every line in the allocated state with a known tag. Boot code then has local memory to work from before external memory is brought up. The data array, coherence and the refill path belong to other blocks.

Top module: `cta_tag_array`

## Requirements
- R1: A lookup request (`lk_valid`) produces `hit_valid` exactly one cycle later, with `hit` and a one-hot `hit_way` (bit w is way w). A way matches when its tag equals `lk_tag` and its state is valid (01) or allocated (10).
- R2: A line in the disabled state (11) never contributes to `hit` or `hit_way`, whatever tag it stores.
- R3: The victim returned on `al_way` (binary way number, one cycle after `al_req`, with `al_done`) is never a disabled line.
- R4: If any way of the set is invalid (00), the victim is the lowest-numbered invalid way, and the set's round-robin pointer does not move.
- R5: Otherwise the victim is the first way that is not disabled, searching upward with wrap from the set's round-robin pointer. The pointer then moves to the way after the chosen one.
- R6: If all ways of the set are disabled, the allocation response sets `al_none` and leaves the pointer unchanged.
- R7: A disable command (`dis_valid`, `dis_index`, `dis_way`) sets that line to disabled from any state, allocated included. It wins over a fill of the same line in the same cycle.
- R8: A fill writes `fl_tag` and takes its state from `fl_mode`: 00 invalidate, 01 valid, 10 allocated. Mode 11 changes nothing, and a fill aimed at a disabled line changes nothing.
- R9: With `BOOT_ALLOC`=0, reset leaves every line invalid. With `BOOT_ALLOC`=1, every line starts allocated, and way w of each set holds tag value w. In both cases all round-robin pointers reset to way 0.
- R10: A set with one disabled line still hits and allocates on its remaining three ways.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_index | input | 6 | Lookup set index |
| lk_tag | input | 20 | Lookup tag |
| hit_valid | output | 1 | Lookup result valid |
| hit | output | 1 | Lookup found the tag |
| hit_way | output | 4 | One-hot matching way |
| al_req | input | 1 | Allocation request |
| al_index | input | 6 | Allocation set index |
| al_done | output | 1 | Allocation result valid |
| al_none | output | 1 | No usable way in the set |
| al_way | output | 2 | Chosen victim way |
| fl_valid | input | 1 | Fill command |
| fl_index | input | 6 | Fill set index |
| fl_way | input | 2 | Fill way |
| fl_tag | input | 20 | Tag to write |
| fl_mode | input | 2 | New state: 00 invalid, 01 valid, 10 allocated, 11 no-op |
| dis_valid | input | 1 | Disable command |
| dis_index | input | 6 | Set of the line to disable |
| dis_way | input | 2 | Way of the line to disable |

## Verification
On every cycle the assertions check the safety rules. A disabled line never shows up in a lookup result. A victim is never disabled. An invalid way is taken before any other. The no-victim flag is set exactly when the whole set is disabled. A disable command always takes effect. The assertions cannot show that the round-robin order is correct across a run of requests, that the boot preload holds the intended tags, that a no-op or blocked fill leaves the old tag alive, or that a degraded set keeps serving its three good ways. Those are shown only by the bench's scenarios, which track expected pointer positions and tags of their own.

// File: rtl/cta_pkg.sv
package cta_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_VAL = 2'b01,
    LS_ALC = 2'b10,
    LS_DIS = 2'b11
  } lstate_e;

  // a line may take part in tag matching only when it holds data
  function automatic logic line_live(input logic [1:0] st);
    return (st == LS_VAL) || (st == LS_ALC);
  endfunction

  // a fill lands unless it is the no-op code or the line is mapped out
  function automatic logic fill_lands(input logic [1:0] cur, input logic [1:0] mode);
    return (mode != 2'b11) && (cur != LS_DIS);
  endfunction

endpackage

// File: rtl/cta_match.sv
module cta_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 20
) (
  input  logic [WAYS-1:0][1:0]       set_st,
  input  logic [WAYS-1:0][TAG_W-1:0] set_tag,
  input  logic [TAG_W-1:0]           tag,
  output logic [WAYS-1:0]            hit_vec
);
  import cta_pkg::*;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = line_live(set_st[w]) && (set_tag[w] == tag);
  end

endmodule

// File: rtl/cta_victim.sv
module cta_victim #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0][1:0] set_st,
  input  logic [WAY_W-1:0]     ptr,
  output logic [WAY_W-1:0]     way,
  output logic                 none,
  output logic                 from_inv,
  output logic [WAYS-1:0]      inv_mask,
  output logic [WAYS-1:0]      dis_mask
);
  import cta_pkg::*;

  for (genvar w = 0; w < WAYS; w++) begin : g_mask
    assign inv_mask[w] = (set_st[w] == LS_INV);
    assign dis_mask[w] = (set_st[w] == LS_DIS);
  end

  always_comb begin
    logic             found;
    logic [WAY_W-1:0] cand;
    found    = 1'b0;
    from_inv = 1'b0;
    way      = '0;
    cand     = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && inv_mask[w]) begin
        found    = 1'b1;
        from_inv = 1'b1;
        way      = WAY_W'(w);
      end
    end
    for (int k = 0; k < WAYS; k++) begin
      cand = ptr + WAY_W'(k);
      if (!found && !dis_mask[cand]) begin
        found = 1'b1;
        way   = cand;
      end
    end
    none = !found;
  end

endmodule

// File: rtl/cta_tag_array.sv
module cta_tag_array #(
  parameter int CACHE_BYTES = 16384,
  parameter int LINE_BYTES  = 64,
  parameter int WAYS        = 4,
  parameter int ADDR_W      = 32,
  parameter bit BOOT_ALLOC  = 1'b0
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    lk_valid,
  input  logic [$clog2(CACHE_BYTES/(LINE_BYTES*WAYS))-1:0] lk_index,
  input  logic [ADDR_W-$clog2(CACHE_BYTES/(LINE_BYTES*WAYS))-$clog2(LINE_BYTES)-1:0] lk_tag,
  output logic                                    hit_valid,
  output logic                                    hit,
  output logic [WAYS-1:0]                         hit_way,
  input  logic                                    al_req,
  input  logic [$clog2(CACHE_BYTES/(LINE_BYTES*WAYS))-1:0] al_index,
  output logic                                    al_done,
  output logic                                    al_none,
  output logic [$clog2(WAYS)-1:0]                 al_way,
  input  logic                                    fl_valid,
  input  logic [$clog2(CACHE_BYTES/(LINE_BYTES*WAYS))-1:0] fl_index,
  input  logic [$clog2(WAYS)-1:0]                 fl_way,
  input  logic [ADDR_W-$clog2(CACHE_BYTES/(LINE_BYTES*WAYS))-$clog2(LINE_BYTES)-1:0] fl_tag,
  input  logic [1:0]                              fl_mode,
  input  logic                                    dis_valid,
  input  logic [$clog2(CACHE_BYTES/(LINE_BYTES*WAYS))-1:0] dis_index,
  input  logic [$clog2(WAYS)-1:0]                 dis_way
);
  import cta_pkg::*;

  localparam int SETS  = CACHE_BYTES / (LINE_BYTES * WAYS);
  localparam int IDX_W = $clog2(SETS);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int WAY_W = $clog2(WAYS);

  logic [WAYS-1:0][1:0]       st_q  [SETS];
  logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];
  logic [WAY_W-1:0]           ptr_q [SETS];

  // observation wires for the checks below
  logic [WAYS-1:0] lk_hit_vec;
  logic [WAYS-1:0] lk_dis_mask;
  logic [WAYS-1:0] al_inv_mask;
  logic [WAYS-1:0] al_dis_mask;
  logic [WAY_W-1:0] vic_way;
  logic            vic_none;
  logic            vic_from_inv;
  logic            fill_ok;

  cta_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .set_st  (st_q[lk_index]),
    .set_tag (tag_q[lk_index]),
    .tag     (lk_tag),
    .hit_vec (lk_hit_vec)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_lkdis
    assign lk_dis_mask[w] = (st_q[lk_index][w] == LS_DIS);
  end

  cta_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
    .set_st   (st_q[al_index]),
    .ptr      (ptr_q[al_index]),
    .way      (vic_way),
    .none     (vic_none),
    .from_inv (vic_from_inv),
    .inv_mask (al_inv_mask),
    .dis_mask (al_dis_mask)
  );

  assign fill_ok = fl_valid && fill_lands(st_q[fl_index][fl_way], fl_mode);

  // line state, tags and round-robin pointers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        ptr_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          st_q[s][w]  <= BOOT_ALLOC ? LS_ALC : LS_INV;
          tag_q[s][w] <= BOOT_ALLOC ? TAG_W'(w) : '0;
        end
      end
    end else begin
      if (fill_ok) begin
        st_q[fl_index][fl_way]  <= fl_mode;
        tag_q[fl_index][fl_way] <= fl_tag;
      end
      if (dis_valid) begin
        st_q[dis_index][dis_way] <= LS_DIS;
      end
      if (al_req && !vic_none && !vic_from_inv) begin
        ptr_q[al_index] <= vic_way + WAY_W'(1);
      end
    end
  end

  // registered responses
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_valid <= 1'b0;
      hit       <= 1'b0;
      hit_way   <= '0;
      al_done   <= 1'b0;
      al_none   <= 1'b0;
      al_way    <= '0;
    end else begin
      hit_valid <= lk_valid;
      hit       <= lk_valid && (|lk_hit_vec);
      hit_way   <= lk_valid ? lk_hit_vec : '0;
      al_done   <= al_req;
      al_none   <= al_req && vic_none;
      al_way    <= al_req ? vic_way : '0;
    end
  end

  // R1: result one cycle after the request
  a_r1_hit_timing: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> hit_valid);

  // R2: mapped-out lines never match
  a_r2_dis_never_hits: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> ((hit_way & $past(lk_dis_mask)) == '0));

  // R3: victim is a usable line
  a_r3_victim_usable: assert property (@(posedge clk) disable iff (!rst_n)
    (al_req && !(&al_dis_mask)) |=>
      (al_done && !al_none && ((($past(al_dis_mask) >> al_way) & WAYS'(1)) == '0)));

  // R4: an empty way is preferred
  a_r4_invalid_first: assert property (@(posedge clk) disable iff (!rst_n)
    (al_req && (|al_inv_mask)) |=> ((($past(al_inv_mask) >> al_way) & WAYS'(1)) != '0));

  // R6: no victim exactly when the whole set is mapped out
  a_r6_none_all_dis: assert property (@(posedge clk) disable iff (!rst_n)
    al_req |=> (al_none == $past(&al_dis_mask)));

  // R7: disable always takes effect
  a_r7_dis_override: assert property (@(posedge clk) disable iff (!rst_n)
    dis_valid |=> (st_q[$past(dis_index)][$past(dis_way)] == LS_DIS));

endmodule

// File: tb/sim_cta_tag_array.sv
`timescale 1ns/1ps
module sim_cta_tag_array;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        lk_valid = 0;
  logic [5:0]  lk_index = 0;
  logic [19:0] lk_tag = 0;
  logic        al_req = 0;
  logic [5:0]  al_index = 0;
  logic        fl_valid = 0;
  logic [5:0]  fl_index = 0;
  logic [1:0]  fl_way = 0;
  logic [19:0] fl_tag = 0;
  logic [1:0]  fl_mode = 0;
  logic        dis_valid = 0;
  logic [5:0]  dis_index = 0;
  logic [1:0]  dis_way = 0;

  logic       hv0, h0, ad0, an0, hv1, h1, ad1, an1;
  logic [3:0] hw0, hw1;
  logic [1:0] aw0, aw1;

  cta_tag_array u0 (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_index(lk_index), .lk_tag(lk_tag),
    .hit_valid(hv0), .hit(h0), .hit_way(hw0),
    .al_req(al_req), .al_index(al_index),
    .al_done(ad0), .al_none(an0), .al_way(aw0),
    .fl_valid(fl_valid), .fl_index(fl_index), .fl_way(fl_way),
    .fl_tag(fl_tag), .fl_mode(fl_mode),
    .dis_valid(dis_valid), .dis_index(dis_index), .dis_way(dis_way)
  );

  cta_tag_array #(.BOOT_ALLOC(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_index(lk_index), .lk_tag(lk_tag),
    .hit_valid(hv1), .hit(h1), .hit_way(hw1),
    .al_req(al_req), .al_index(al_index),
    .al_done(ad1), .al_none(an1), .al_way(aw1),
    .fl_valid(fl_valid), .fl_index(fl_index), .fl_way(fl_way),
    .fl_tag(fl_tag), .fl_mode(fl_mode),
    .dis_valid(dis_valid), .dis_index(dis_index), .dis_way(dis_way)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one-cycle operations: drive at negedge, results visible at next negedge
  task automatic op_lookup(input logic [5:0] idx, input logic [19:0] tag);
    lk_valid = 1; lk_index = idx; lk_tag = tag;
    @(posedge clk); @(negedge clk);
    lk_valid = 0;
  endtask

  task automatic op_alloc(input logic [5:0] idx);
    al_req = 1; al_index = idx;
    @(posedge clk); @(negedge clk);
    al_req = 0;
  endtask

  task automatic op_fill(input logic [5:0] idx, input logic [1:0] way,
                         input logic [19:0] tag, input logic [1:0] mode);
    fl_valid = 1; fl_index = idx; fl_way = way; fl_tag = tag; fl_mode = mode;
    @(posedge clk); @(negedge clk);
    fl_valid = 0;
  endtask

  task automatic op_dis(input logic [5:0] idx, input logic [1:0] way);
    dis_valid = 1; dis_index = idx; dis_way = way;
    @(posedge clk); @(negedge clk);
    dis_valid = 0;
  endtask

  task automatic expect_hit(input string req, input logic [5:0] idx,
                            input logic [19:0] tag, input logic [3:0] onehot);
    op_lookup(idx, tag);
    chk(req, "hit_valid", hv0, 1);
    chk(req, "hit", h0, (onehot != 0));
    chk(req, "hit_way", hw0, onehot);
  endtask

  task automatic expect_alloc(input string req, input logic [5:0] idx,
                              input logic none, input logic [1:0] way);
    op_alloc(idx);
    chk(req, "al_done", ad0, 1);
    chk(req, "al_none", an0, none);
    if (!none) chk(req, "al_way", aw0, way);
  endtask

  task automatic t_reset;
    chk("R9", "hit_valid after reset", hv0, 0);
    chk("R9", "al_done after reset", ad0, 0);
    expect_hit("R9", 6'd5, 20'd0, 4'b0000);
    op_lookup(6'd5, 20'd2);
    chk("R9", "boot hit", h1, 1);
    chk("R9", "boot hit_way", hw1, 4'b0100);
    op_lookup(6'd5, 20'd4);
    chk("R9", "boot miss", h1, 0);
    op_alloc(6'd0);
    chk("R9", "boot ptr zero", aw1, 0);
    expect_alloc("R4", 6'd9, 0, 2'd0);
  endtask

  task automatic t_fill_modes;
    op_fill(6'd3, 2'd1, 20'hABCDE, 2'b01);
    expect_hit("R1", 6'd3, 20'hABCDE, 4'b0010);
    expect_hit("R1", 6'd3, 20'hABCDF, 4'b0000);
    op_fill(6'd3, 2'd1, 20'h11111, 2'b11);
    expect_hit("R8", 6'd3, 20'hABCDE, 4'b0010);
    op_fill(6'd3, 2'd1, 20'hABCDE, 2'b00);
    expect_hit("R8", 6'd3, 20'hABCDE, 4'b0000);
  endtask

  task automatic t_invalid_first;
    op_fill(6'd10, 2'd0, 20'h100, 2'b01);
    op_fill(6'd10, 2'd1, 20'h101, 2'b01);
    expect_alloc("R4", 6'd10, 0, 2'd2);
    expect_alloc("R4", 6'd10, 0, 2'd2);
  endtask

  task automatic t_round_robin;
    for (int w = 0; w < 4; w++) op_fill(6'd20, 2'(w), 20'h200 + 20'(w), 2'b01);
    expect_alloc("R5", 6'd20, 0, 2'd0);
    expect_alloc("R5", 6'd20, 0, 2'd1);
    expect_alloc("R5", 6'd20, 0, 2'd2);
    expect_alloc("R5", 6'd20, 0, 2'd3);
    expect_alloc("R5", 6'd20, 0, 2'd0);
    op_dis(6'd20, 2'd1);
    expect_hit("R2", 6'd20, 20'h201, 4'b0000);
    expect_alloc("R3", 6'd20, 0, 2'd2);
    expect_alloc("R3", 6'd20, 0, 2'd3);
    expect_alloc("R3", 6'd20, 0, 2'd0);
    expect_alloc("R10", 6'd20, 0, 2'd2);
    expect_hit("R10", 6'd20, 20'h202, 4'b0100);
    expect_hit("R10", 6'd20, 20'h203, 4'b1000);
    op_fill(6'd20, 2'd1, 20'h201, 2'b01);
    expect_hit("R8", 6'd20, 20'h201, 4'b0000);
  endtask

  task automatic t_disable_pinned;
    op_fill(6'd30, 2'd0, 20'h300, 2'b10);
    expect_hit("R7", 6'd30, 20'h300, 4'b0001);
    op_dis(6'd30, 2'd0);
    expect_hit("R7", 6'd30, 20'h300, 4'b0000);
    expect_alloc("R3", 6'd30, 0, 2'd1);
  endtask

  task automatic t_no_victim;
    for (int w = 0; w < 4; w++) op_dis(6'd40, 2'(w));
    expect_alloc("R6", 6'd40, 1, 2'd0);
    op_dis(6'd41, 2'd0);
    op_dis(6'd41, 2'd1);
    expect_alloc("R4", 6'd41, 0, 2'd2);
  endtask

  task automatic t_collision;
    fl_valid = 1; fl_index = 6'd50; fl_way = 2'd3; fl_tag = 20'h500; fl_mode = 2'b01;
    dis_valid = 1; dis_index = 6'd50; dis_way = 2'd3;
    @(posedge clk); @(negedge clk);
    fl_valid = 0; dis_valid = 0;
    expect_hit("R7", 6'd50, 20'h500, 4'b0000);
    expect_alloc("R7", 6'd50, 0, 2'd0);
    for (int w = 0; w < 3; w++) op_dis(6'd50, 2'(w));
    expect_alloc("R7", 6'd50, 1, 2'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    t_reset();
    t_fill_modes();
    t_invalid_first();
    t_round_robin();
    t_disable_pinned();
    t_no_victim();
    t_collision();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule